// File: doc/BRIEF.md
# ModRM/SIB displacement sizer

This block sits in the byte framer of a variable-length instruction decoder. When the framer presents the addressing-form byte (ModRM) of an instruction, the sizer works out whether a scale-index-base byte (SIB) must come next. It also works out how many displacement bytes follow, and whether the preliminary immediate length has to be corrected for the group-3 test form. From these it picks the framer's next step.

When a SIB byte is presented afterwards, the sizer revisits the displacement length and chooses the next step again. All results are registered and hold their values until the next ModRM byte arrives, until a SIB byte is taken, or until the framer acknowledges that it has collected the fields. It does not compute effective addresses.

Top module: `modrm_sib_sizer`

## Requirements
- R1: When `modrm_valid` is high and `addr_size` is 0 (2-byte addressing), `disp_size` in the next cycle is 2 if mod (ModRM bits 7:6) is 0 and rm (bits 2:0) is 6. It is also 2 if mod is 2, 1 if mod is 1, and 0 otherwise.
- R2: When `modrm_valid` is high and `addr_size` is 1 or 2 (4- or 8-byte addressing), `disp_size` in the next cycle is 4 if mod is 0 and rm is 5. It is also 4 if mod is 2, 1 if mod is 1, and 0 otherwise.
- R3: `need_sib` goes high in the cycle after `modrm_valid` only when rm is 4, mod is not 3 and `addr_size` is not 0.
- R4: A SIB byte accepted while `need_sib` is high sets `disp_size` to 4 when the latched mod is 0 and the SIB base field (bits 2:0) is 5. Otherwise `disp_size` keeps its value. `need_sib` then drops.
- R5: With `opc_map` 0 (one-byte map) and ModRM reg field (bits 5:3) having bits 2:1 both zero, opcode F6 gives `imm_size` 1. Under the same conditions, opcode F7 gives `imm_size` equal to `op_size`, except that 8 becomes 4. In all other cases `imm_size` takes `imm_prelim`.
- R6: `next_step` is chosen by priority: 0 (SIB) if a SIB is needed, else 1 (DISP) if `disp_size` is non-zero, else 2 (IMM) if `imm_size` is non-zero, else 3 (DONE).
- R7: After an accepted SIB byte, `next_step` is chosen again among DISP, IMM and DONE, using the updated displacement and the held immediate size.
- R8: Every `modrm_valid` latches the ModRM byte on `modrm_latched` in the next cycle, whatever step is chosen.
- R9: Without `modrm_valid`, an accepted SIB or `fields_ack`, all outputs hold. `fields_ack` alone clears `disp_size`, `imm_size` and `need_sib` and sets `next_step` to 3. `modrm_valid` takes priority over a SIB byte, and a SIB byte takes priority over `fields_ack`.
- R10: After reset, `need_sib` is 0, `disp_size` is 0, `imm_size` is 0, `next_step` is 3 and `modrm_latched` is 0.
- R11: `sib_valid` while `need_sib` is low changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| modrm_valid | input | 1 | ModRM byte present; starts a new sizing |
| modrm | input | 8 | ModRM byte |
| sib_valid | input | 1 | SIB byte present |
| sib | input | 8 | SIB byte |
| addr_size | input | 2 | 0 = 2-byte, 1 = 4-byte, 2 = 8-byte addressing |
| opc_map | input | 2 | Opcode map, 0 = one-byte map |
| opc_byte | input | 8 | Final opcode byte |
| op_size | input | 4 | Operand size in bytes (2, 4 or 8) |
| imm_prelim | input | 4 | Immediate size from opcode lookup, bytes |
| fields_ack | input | 1 | Framer has collected the fields |
| need_sib | output | 1 | A SIB byte is still expected |
| disp_size | output | 3 | Displacement length in bytes (0, 1, 2, 4) |
| imm_size | output | 4 | Corrected immediate length in bytes |
| next_step | output | 2 | 0 SIB, 1 DISP, 2 IMM, 3 DONE |
| modrm_latched | output | 8 | Last accepted ModRM byte |

## Verification
The assertions assume that `addr_size` never carries the value 3, that `op_size` is one of 2, 4 or 8, and that the framer presents at most one of `modrm_valid`, an expected SIB, or `fields_ack` per instruction step in a sane order. The stimulus keeps to legal address and operand encodings and only raises one strobe per cycle. The one exception is the priority test, which raises several strobes together to exercise the ordering. Stray SIB strobes are sent only to confirm they are ignored.

// File: rtl/msz_pkg.sv
package msz_pkg;
  localparam int unsigned DISP_W = 3;
  localparam int unsigned IMM_W  = 4;

  localparam logic [1:0] ADDR_16 = 2'd0;
  localparam logic [1:0] MAP_ONE = 2'd0;

  typedef enum logic [1:0] {
    STEP_SIB  = 2'd0,
    STEP_DISP = 2'd1,
    STEP_IMM  = 2'd2,
    STEP_DONE = 2'd3
  } step_e;

  typedef struct packed {
    logic [1:0] mode;
    logic [2:0] reg_f;
    logic [2:0] rm;
  } modrm_t;
endpackage

// File: rtl/msz_disp_decode.sv
module msz_disp_decode
  import msz_pkg::*;
#(
  parameter int unsigned DW = DISP_W
) (
  input  logic [7:0]    modrm_byte,
  input  logic [1:0]    addr_mode,
  output logic [DW-1:0] disp_bytes,
  output logic          sib_follows
);
  modrm_t f;
  logic   narrow;

  assign f      = modrm_t'(modrm_byte);
  assign narrow = (addr_mode == ADDR_16);

  always_comb begin
    disp_bytes = '0;
    if (narrow) begin
      if ((f.mode == 2'd0 && f.rm == 3'd6) || f.mode == 2'd2)
        disp_bytes = DW'(2);
      else if (f.mode == 2'd1)
        disp_bytes = DW'(1);
    end else begin
      if ((f.mode == 2'd0 && f.rm == 3'd5) || f.mode == 2'd2)
        disp_bytes = DW'(4);
      else if (f.mode == 2'd1)
        disp_bytes = DW'(1);
    end
  end

  assign sib_follows = !narrow && (f.rm == 3'd4) && (f.mode != 2'd3);
endmodule

// File: rtl/msz_imm_fix.sv
module msz_imm_fix
  import msz_pkg::*;
#(
  parameter int unsigned IW  = IMM_W,
  parameter int unsigned CAP = 4
) (
  input  logic [1:0]    map_sel,
  input  logic [7:0]    opcode,
  input  logic [2:0]    reg_field,
  input  logic [IW-1:0] opnd_bytes,
  input  logic [IW-1:0] imm_in,
  output logic [IW-1:0] imm_out
);
  localparam logic [IW-1:0] CAP_V = IW'(CAP);
  logic test_form;

  assign test_form = (map_sel == MAP_ONE) && (reg_field[2:1] == 2'b00);

  always_comb begin
    imm_out = imm_in;
    if (test_form && opcode == 8'hF6)
      imm_out = IW'(1);
    else if (test_form && opcode == 8'hF7)
      imm_out = (opnd_bytes > CAP_V) ? CAP_V : opnd_bytes;
  end
endmodule

// File: rtl/msz_step_pick.sv
module msz_step_pick
  import msz_pkg::*;
#(
  parameter int unsigned DW = DISP_W,
  parameter int unsigned IW = IMM_W
) (
  input  logic          want_sib,
  input  logic [DW-1:0] disp_bytes,
  input  logic [IW-1:0] imm_bytes,
  output step_e         step
);
  always_comb begin
    if (want_sib)                step = STEP_SIB;
    else if (disp_bytes != '0)   step = STEP_DISP;
    else if (imm_bytes != '0)    step = STEP_IMM;
    else                         step = STEP_DONE;
  end
endmodule

// File: rtl/modrm_sib_sizer.sv
module modrm_sib_sizer
  import msz_pkg::*;
#(
  parameter int unsigned DW = DISP_W,
  parameter int unsigned IW = IMM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          modrm_valid,
  input  logic [7:0]    modrm,
  input  logic          sib_valid,
  input  logic [7:0]    sib,
  input  logic [1:0]    addr_size,
  input  logic [1:0]    opc_map,
  input  logic [7:0]    opc_byte,
  input  logic [IW-1:0] op_size,
  input  logic [IW-1:0] imm_prelim,
  input  logic          fields_ack,
  output logic          need_sib,
  output logic [DW-1:0] disp_size,
  output logic [IW-1:0] imm_size,
  output logic [1:0]    next_step,
  output logic [7:0]    modrm_latched
);
  localparam int unsigned NPICK = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ok_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok_n = rst_pipe[1];

  // decode paths
  logic [DW-1:0] dec_disp;
  logic          dec_sib;
  logic [IW-1:0] fix_imm;
  logic [DW-1:0] sib_disp;
  modrm_t        held;

  msz_disp_decode #(.DW(DW)) u_disp (
    .modrm_byte (modrm),
    .addr_mode  (addr_size),
    .disp_bytes (dec_disp),
    .sib_follows(dec_sib)
  );

  msz_imm_fix #(.IW(IW), .CAP(4)) u_imm (
    .map_sel   (opc_map),
    .opcode    (opc_byte),
    .reg_field (modrm[5:3]),
    .opnd_bytes(op_size),
    .imm_in    (imm_prelim),
    .imm_out   (fix_imm)
  );

  logic          sib_q;
  logic [DW-1:0] disp_q;
  logic [IW-1:0] imm_q;
  step_e         step_q;
  logic [7:0]    mrm_q;

  assign held     = modrm_t'(mrm_q);
  assign sib_disp = (held.mode == 2'd0 && sib[2:0] == 3'd5) ? DW'(4) : disp_q;

  // step choice for the ModRM path [0] and the post-SIB path [1]
  logic          pk_sib  [NPICK];
  logic [DW-1:0] pk_disp [NPICK];
  logic [IW-1:0] pk_imm  [NPICK];
  step_e         pk_step [NPICK];

  assign pk_sib[0]  = dec_sib;
  assign pk_disp[0] = dec_disp;
  assign pk_imm[0]  = fix_imm;
  assign pk_sib[1]  = 1'b0;
  assign pk_disp[1] = sib_disp;
  assign pk_imm[1]  = imm_q;

  for (genvar g = 0; g < NPICK; g++) begin : g_pick
    msz_step_pick #(.DW(DW), .IW(IW)) u_pick (
      .want_sib  (pk_sib[g]),
      .disp_bytes(pk_disp[g]),
      .imm_bytes (pk_imm[g]),
      .step      (pk_step[g])
    );
  end

  // next state
  logic          take_sib;
  logic          upd_en;
  logic          sib_n;
  logic [DW-1:0] disp_n;
  logic [IW-1:0] imm_n;
  step_e         step_n;
  logic [7:0]    mrm_n;

  assign take_sib = sib_valid && sib_q;
  assign upd_en   = modrm_valid || take_sib || fields_ack;

  always_comb begin
    sib_n  = sib_q;
    disp_n = disp_q;
    imm_n  = imm_q;
    step_n = step_q;
    mrm_n  = mrm_q;
    if (modrm_valid) begin
      sib_n  = dec_sib;
      disp_n = dec_disp;
      imm_n  = fix_imm;
      step_n = pk_step[0];
      mrm_n  = modrm;
    end else if (take_sib) begin
      sib_n  = 1'b0;
      disp_n = sib_disp;
      step_n = pk_step[1];
    end else if (fields_ack) begin
      sib_n  = 1'b0;
      disp_n = '0;
      imm_n  = '0;
      step_n = STEP_DONE;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      sib_q  <= 1'b0;
      disp_q <= '0;
      imm_q  <= '0;
      step_q <= STEP_DONE;
      mrm_q  <= 8'h00;
    end else if (upd_en) begin
      sib_q  <= sib_n;
      disp_q <= disp_n;
      imm_q  <= imm_n;
      step_q <= step_n;
      mrm_q  <= mrm_n;
    end
  end

  assign need_sib      = sib_q;
  assign disp_size     = disp_q;
  assign imm_size      = imm_q;
  assign next_step     = step_q;
  assign modrm_latched = mrm_q;

  // checks
  assert_narrow_disp_R1: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (modrm_valid && addr_size == ADDR_16) |=> (disp_size != DW'(4)));

  assert_wide_mod2_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (modrm_valid && addr_size != ADDR_16 && modrm[7:6] == 2'd2) |=> (disp_size == DW'(4)));

  assert_no_sib_narrow_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (modrm_valid && addr_size == ADDR_16) |=> !need_sib);

  assert_base5_R4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!modrm_valid && sib_valid && need_sib && modrm_latched[7:6] == 2'd0 && sib[2:0] == 3'd5)
      |=> (disp_size == DW'(4) && !need_sib));

  assert_sib_step_R6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    need_sib |-> (next_step == STEP_SIB));

  assert_done_empty_R6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (next_step == STEP_DONE) |-> (disp_size == '0 && imm_size == '0 && !need_sib));

  assert_resel_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!modrm_valid && sib_valid && need_sib) |=> (next_step != STEP_SIB));

  assert_latch_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    modrm_valid |=> (modrm_latched == $past(modrm)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!modrm_valid && !(sib_valid && need_sib) && !fields_ack)
      |=> ($stable(disp_size) && $stable(imm_size) && $stable(next_step) && $stable(need_sib)));

  assert_ack_R9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (fields_ack && !modrm_valid && !(sib_valid && need_sib))
      |=> (disp_size == '0 && imm_size == '0 && next_step == STEP_DONE));
endmodule

// File: tb/modrm_sib_sizer_bench.sv
`timescale 1ns/1ps
module modrm_sib_sizer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       modrm_valid, sib_valid, fields_ack;
  logic [7:0] modrm, sib, opc_byte;
  logic [1:0] addr_size, opc_map;
  logic [3:0] op_size, imm_prelim;
  logic       need_sib;
  logic [2:0] disp_size;
  logic [3:0] imm_size;
  logic [1:0] next_step;
  logic [7:0] modrm_latched;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  modrm_sib_sizer u_modrm_sib_sizer (
    .clk(clk), .rst_n(rst_n),
    .modrm_valid(modrm_valid), .modrm(modrm),
    .sib_valid(sib_valid), .sib(sib),
    .addr_size(addr_size), .opc_map(opc_map), .opc_byte(opc_byte),
    .op_size(op_size), .imm_prelim(imm_prelim), .fields_ack(fields_ack),
    .need_sib(need_sib), .disp_size(disp_size), .imm_size(imm_size),
    .next_step(next_step), .modrm_latched(modrm_latched)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [1:0] asz;
    logic [1:0] map;
    logic [7:0] opc;
    logic [3:0] osz;
    logic [3:0] immp;
    logic [7:0] mrm;
    logic       e_sib;
    logic [2:0] e_disp;
    logic [3:0] e_imm;
    logic [1:0] e_step;
  } vec_t;

  localparam int NV = 18;
  // step codes: 0 SIB, 1 DISP, 2 IMM, 3 DONE
  localparam vec_t VEC [NV] = '{
    '{4'd1, 2'd0, 2'd0, 8'h8B, 4'd2, 4'd0, 8'h06, 1'b0, 3'd2, 4'd0, 2'd1}, // R1 mod0 rm6
    '{4'd1, 2'd0, 2'd0, 8'h8B, 4'd2, 4'd0, 8'h46, 1'b0, 3'd1, 4'd0, 2'd1}, // R1 mod1
    '{4'd1, 2'd0, 2'd0, 8'h8B, 4'd2, 4'd0, 8'h86, 1'b0, 3'd2, 4'd0, 2'd1}, // R1 mod2
    '{4'd3, 2'd0, 2'd0, 8'h8B, 4'd2, 4'd0, 8'h04, 1'b0, 3'd0, 4'd0, 2'd3}, // R3 no SIB at 16-bit
    '{4'd1, 2'd0, 2'd0, 8'h8B, 4'd2, 4'd0, 8'h05, 1'b0, 3'd0, 4'd0, 2'd3}, // R1 rm5 not special
    '{4'd2, 2'd1, 2'd0, 8'h8B, 4'd4, 4'd0, 8'h05, 1'b0, 3'd4, 4'd0, 2'd1}, // R2 mod0 rm5
    '{4'd2, 2'd1, 2'd0, 8'h8B, 4'd4, 4'd0, 8'h06, 1'b0, 3'd0, 4'd0, 2'd3}, // R2 rm6 plain
    '{4'd2, 2'd2, 2'd0, 8'h8B, 4'd4, 4'd0, 8'h85, 1'b0, 3'd4, 4'd0, 2'd1}, // R2 mod2 64-bit
    '{4'd3, 2'd1, 2'd0, 8'h8B, 4'd4, 4'd0, 8'h44, 1'b1, 3'd1, 4'd0, 2'd0}, // R3 SIB first
    '{4'd3, 2'd1, 2'd0, 8'h80, 4'd4, 4'd1, 8'hC4, 1'b0, 3'd0, 4'd1, 2'd2}, // R3 mod3 no SIB
    '{4'd5, 2'd1, 2'd0, 8'hF6, 4'd4, 4'd0, 8'hC0, 1'b0, 3'd0, 4'd1, 2'd2}, // R5 F6 test
    '{4'd5, 2'd1, 2'd0, 8'hF7, 4'd8, 4'd0, 8'hC8, 1'b0, 3'd0, 4'd4, 2'd2}, // R5 F7 cap 8->4
    '{4'd5, 2'd1, 2'd0, 8'hF7, 4'd2, 4'd0, 8'hC0, 1'b0, 3'd0, 4'd2, 2'd2}, // R5 F7 opsize 2
    '{4'd5, 2'd1, 2'd0, 8'hF7, 4'd4, 4'd0, 8'hD0, 1'b0, 3'd0, 4'd0, 2'd3}, // R5 reg2 not test
    '{4'd5, 2'd1, 2'd1, 8'hF6, 4'd4, 4'd0, 8'hC0, 1'b0, 3'd0, 4'd0, 2'd3}, // R5 other map
    '{4'd5, 2'd1, 2'd0, 8'hF6, 4'd4, 4'd0, 8'hD8, 1'b0, 3'd0, 4'd0, 2'd3}, // R5 reg3 not test
    '{4'd6, 2'd1, 2'd0, 8'hF7, 4'd4, 4'd0, 8'h40, 1'b0, 3'd1, 4'd4, 2'd1}, // R6 disp before imm
    '{4'd6, 2'd2, 2'd0, 8'h81, 4'd8, 4'd4, 8'h00, 1'b0, 3'd0, 4'd4, 2'd2}  // R6 imm only
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_all(input string tag, input int s, input int d, input int i, input int st);
    chk({tag, " need_sib"}, int'(need_sib), s);
    chk({tag, " disp_size"}, int'(disp_size), d);
    chk({tag, " imm_size"}, int'(imm_size), i);
    chk({tag, " next_step"}, int'(next_step), st);
  endtask

  // drive after a falling edge, pulse one cycle, check at the next falling edge
  task automatic send_modrm(input logic [1:0] asz, input logic [1:0] map, input logic [7:0] opc,
                            input logic [3:0] osz, input logic [3:0] immp, input logic [7:0] mrm);
    addr_size = asz; opc_map = map; opc_byte = opc;
    op_size = osz; imm_prelim = immp; modrm = mrm; modrm_valid = 1'b1;
    @(negedge clk);
    modrm_valid = 1'b0;
  endtask

  task automatic send_sib(input logic [7:0] b);
    sib = b; sib_valid = 1'b1;
    @(negedge clk);
    sib_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    modrm_valid = 1'b0; sib_valid = 1'b0; fields_ack = 1'b0;
    modrm = 8'h00; sib = 8'h00; opc_byte = 8'h00;
    addr_size = 2'd1; opc_map = 2'd0; op_size = 4'd4; imm_prelim = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    expect_all("R10 reset", 0, 0, 0, 3);
    chk("R10 modrm_latched", int'(modrm_latched), 0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      string t;
      t = $sformatf("R%0d vec%0d", VEC[k].req, k);
      send_modrm(VEC[k].asz, VEC[k].map, VEC[k].opc, VEC[k].osz, VEC[k].immp, VEC[k].mrm);
      expect_all(t, int'(VEC[k].e_sib), int'(VEC[k].e_disp), int'(VEC[k].e_imm), int'(VEC[k].e_step));
      chk({t, " R8 latch"}, int'(modrm_latched), int'(VEC[k].mrm));
    end

    // R4/R7: mod0 rm4 then base 5 -> 4-byte displacement, step DISP
    send_modrm(2'd1, 2'd0, 8'h8B, 4'd4, 4'd0, 8'h04);
    expect_all("R3 sib pending", 1, 0, 0, 0);
    send_sib(8'h25);
    expect_all("R4 base5 mod0", 0, 4, 0, 1);

    // R4: mod1 with base 5 keeps the 1-byte displacement
    send_modrm(2'd2, 2'd0, 8'h8B, 4'd4, 4'd0, 8'h44);
    send_sib(8'h05);
    expect_all("R4 base5 mod1", 0, 1, 0, 1);

    // R7: after SIB, no displacement, immediate held -> IMM
    send_modrm(2'd1, 2'd0, 8'h80, 4'd4, 4'd2, 8'h04);
    send_sib(8'h00);
    expect_all("R7 to imm", 0, 0, 2, 2);

    // R7: after SIB, nothing left -> DONE
    send_modrm(2'd1, 2'd0, 8'h8B, 4'd4, 4'd0, 8'h0C);
    send_sib(8'h11);
    expect_all("R7 to done", 0, 0, 0, 3);

    // R11: stray SIB with nothing pending changes nothing
    send_modrm(2'd0, 2'd0, 8'h8B, 4'd2, 4'd0, 8'h86);
    send_sib(8'h25);
    expect_all("R11 stray sib", 0, 2, 0, 1);

    // R9: hold while inputs wiggle without strobes
    modrm = 8'h05; addr_size = 2'd1; imm_prelim = 4'd4; sib = 8'h05;
    repeat (3) @(negedge clk);
    expect_all("R9 hold", 0, 2, 0, 1);
    chk("R9 R8 latch hold", int'(modrm_latched), 32'h86);

    // R9: ack clears
    fields_ack = 1'b1;
    @(negedge clk);
    fields_ack = 1'b0;
    expect_all("R9 ack", 0, 0, 0, 3);

    // R9: ack while SIB pending, SIB arrives same cycle -> SIB wins
    send_modrm(2'd1, 2'd0, 8'h8B, 4'd4, 4'd0, 8'h04);
    sib = 8'h05; sib_valid = 1'b1; fields_ack = 1'b1;
    @(negedge clk);
    sib_valid = 1'b0; fields_ack = 1'b0;
    expect_all("R9 sib over ack", 0, 4, 0, 1);

    // R9: ModRM wins over ack and SIB together
    modrm = 8'h46; addr_size = 2'd0; imm_prelim = 4'd0; opc_byte = 8'h8B;
    modrm_valid = 1'b1; fields_ack = 1'b1; sib_valid = 1'b1;
    @(negedge clk);
    modrm_valid = 1'b0; fields_ack = 1'b0; sib_valid = 1'b0;
    expect_all("R9 modrm first", 0, 1, 0, 1);

    // R10: reset again mid-operation
    rst_n = 1'b0;
    @(negedge clk);
    expect_all("R10 async reset", 0, 0, 0, 3);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_all("R10 after release", 0, 0, 0, 3);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule